// File: doc/BRIEF.md
# Shared PCI Interrupt Line Router

This block takes eight level-sensitive shared PCI interrupt lines (lines A to H, index 0 to 7) and one power-management event level (the ACPI SCI), and produces a 24-bit vector of global system interrupt (GSI) levels. The low 16 GSIs feed a legacy interrupt controller. The top 8 feed an APIC.

Every shared line goes one-to-one to its own APIC pin, GSI 16 + n. A byte-wide steering register per line can also place the line on one of the 16 legacy inputs. Several lines may share a legacy input, and that input is then their wired-OR. A three-bit code selects which GSI carries the SCI. If the code changes while the SCI is high, the level moves to the new pin in the same clock edge that releases the old one.

Steering state is written through a synchronous byte write port. All outputs come from registers, so each output reflects its inputs after one clock.

Top module: `pirq_router`

## Requirements
- R1: While `rst` is high and after it is released, all steering bytes hold 0x80 and the SCI target is GSI 9. All outputs are 0 during reset. With default steering no line reaches GSI 0–15.
- R2: Line n (0–7) drives GSI 16+n whatever its steering byte holds.
- R3: A steering byte with bit 7 clear and bits [6:0] equal to k (k < 16) makes that line drive GSI k.
- R4: A legacy GSI is the OR of every line steered to it.
- R5: A steering byte with bit 7 set removes that line from all legacy GSIs.
- R6: A steering byte with bit 7 clear and bits [6:0] of 16 or more removes that line from all legacy GSIs. It does not wrap onto a lower pin.
- R7: A write of code c in bits [2:0] to address 0x10 sets the SCI target as follows:
  - c = 0 selects GSI 9.
  - c = 1 selects GSI 10.
  - c = 2 selects GSI 11.
  - c = 4 selects GSI 20.
  - c = 5 selects GSI 21.

  The SCI level is ORed onto the target pin.
- R8: Codes 3, 6 and 7 written to address 0x10 leave the SCI target unchanged.
- R9: Reselecting the target while the SCI is high clears the old pin and sets the new pin on the same clock edge.
- R10: Every output changes on the first rising clock edge after the input or steering write that causes the change. It does not change before that edge.
- R11: Steering bytes for lines A–D are at addresses 0x00–0x03 and for lines E–H at 0x08–0x0B. Writes to any other address, except 0x10, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the steering registers |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 8 | Byte written |
| pirq_in | input | 8 | Shared interrupt line levels, bit n = line n |
| sci_in | input | 1 | SCI level |
| gsi_out | output | 24 | Registered GSI levels, bit k = GSI k |

## Verification
The bench drives the lines with complementary alternating patterns. A wrong one-to-one APIC mapping shows up as a swapped bit.

It drives pairs of lines onto one legacy pin, one at a time and together, to separate a true OR from a last-writer mux. It also drives steering bytes with the disable flag set and with out-of-range numbers such as 16. A number taken modulo 16 would show up on GSI 0.

Every SCI code is tried, including reserved codes after a valid one. The target is also moved while the SCI is held high, to show that the level is released and taken up in one edge. Writes to the gap between the two steering groups must leave every pin as before.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int BYTE_W   = 8;
  localparam int FLAG_BIT = 7;
  localparam int IRQ_W    = 7;
  localparam int SCI_CW   = 3;
  localparam int GSI_IW   = 5;

  typedef logic [BYTE_W-1:0] route_t;

  typedef struct packed {
    logic              ok;
    logic [GSI_IW-1:0] gsi;
  } sci_sel_t;

  function automatic sci_sel_t sci_decode(input logic [SCI_CW-1:0] code);
    sci_sel_t s;
    s.ok  = 1'b1;
    s.gsi = GSI_IW'(9);
    case (code)
      3'd0: s.gsi = GSI_IW'(9);
      3'd1: s.gsi = GSI_IW'(10);
      3'd2: s.gsi = GSI_IW'(11);
      3'd4: s.gsi = GSI_IW'(20);
      3'd5: s.gsi = GSI_IW'(21);
      default: s.ok = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_pkg::*;
#(
  parameter int     GROUP_SIZE = 4,
  parameter int     ADDR_W     = 8,
  parameter int     GRP0_BASE  = 0,
  parameter int     GRP1_BASE  = 8,
  parameter int     SCI_ADDR   = 16,
  parameter route_t ROUTE_DEF  = 8'h80,
  parameter int     SCI_DEF    = 9,
  localparam int    NUM_PIRQ   = 2 * GROUP_SIZE
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [BYTE_W-1:0]                  wr_data,
  output logic [NUM_PIRQ-1:0][BYTE_W-1:0]    route_q,
  output logic [GSI_IW-1:0]                  sci_gsi
);

  sci_sel_t sel;
  logic     sci_wr;

  assign sel    = sci_decode(wr_data[SCI_CW-1:0]);
  assign sci_wr = wr_en && (wr_addr == ADDR_W'(SCI_ADDR));

  for (genvar i = 0; i < NUM_PIRQ; i++) begin : g_route
    localparam int ADDR_I = (i < GROUP_SIZE) ? (GRP0_BASE + i)
                                             : (GRP1_BASE + i - GROUP_SIZE);
    always_ff @(posedge clk) begin
      if (rst) begin
        route_q[i] <= ROUTE_DEF;
      end else if (wr_en && (wr_addr == ADDR_W'(ADDR_I))) begin
        route_q[i] <= wr_data;
      end
    end

    // R1: default steering right after reset
    p_route_default_r1: assert property (@(posedge clk)
      $past(rst) |-> (route_q[i] == ROUTE_DEF));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sci_gsi <= GSI_IW'(SCI_DEF);
    end else if (sci_wr && sel.ok) begin
      sci_gsi <= sel.gsi;
    end
  end

  // R8: reserved codes keep the target
  p_reserved_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (sci_wr && !sel.ok) |=> $stable(sci_gsi));

  // R7: target is always one of the five legal pins
  p_sci_legal_r7: assert property (@(posedge clk) disable iff (rst)
    (sci_gsi == 5'd9) || (sci_gsi == 5'd10) || (sci_gsi == 5'd11) ||
    (sci_gsi == 5'd20) || (sci_gsi == 5'd21));

endmodule

// File: rtl/pirq_legacy_merge.sv
module pirq_legacy_merge
  import pirq_pkg::*;
#(
  parameter int NUM_PIRQ   = 8,
  parameter int NUM_LEGACY = 16
) (
  input  logic [NUM_PIRQ-1:0]             pirq_lvl,
  input  logic [NUM_PIRQ-1:0][BYTE_W-1:0] route_q,
  input  logic                            sci_lvl,
  input  logic [GSI_IW-1:0]               sci_gsi,
  output logic [NUM_LEGACY-1:0]           legacy
);

  for (genvar k = 0; k < NUM_LEGACY; k++) begin : g_pin
    logic [NUM_PIRQ-1:0] hit;
    for (genvar i = 0; i < NUM_PIRQ; i++) begin : g_src
      assign hit[i] = pirq_lvl[i] && !route_q[i][FLAG_BIT] &&
                      (route_q[i][IRQ_W-1:0] == IRQ_W'(k));
    end
    assign legacy[k] = (|hit) || (sci_lvl && (sci_gsi == GSI_IW'(k)));
  end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int GROUP_SIZE = 4,
  parameter int NUM_LEGACY = 16,
  parameter int ADDR_W     = 8,
  localparam int NUM_PIRQ  = 2 * GROUP_SIZE,
  localparam int NUM_GSI   = NUM_LEGACY + NUM_PIRQ
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [NUM_PIRQ-1:0] pirq_in,
  input  logic                sci_in,
  output logic [NUM_GSI-1:0]  gsi_out
);

  logic [NUM_PIRQ-1:0][BYTE_W-1:0] route_q;
  logic [GSI_IW-1:0]               sci_gsi;
  logic [NUM_LEGACY-1:0]           legacy;
  logic [NUM_PIRQ-1:0]             apic;

  pirq_cfg_regs #(
    .GROUP_SIZE(GROUP_SIZE),
    .ADDR_W    (ADDR_W)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .route_q(route_q),
    .sci_gsi(sci_gsi)
  );

  pirq_legacy_merge #(
    .NUM_PIRQ  (NUM_PIRQ),
    .NUM_LEGACY(NUM_LEGACY)
  ) u_legacy (
    .pirq_lvl(pirq_in),
    .route_q (route_q),
    .sci_lvl (sci_in),
    .sci_gsi (sci_gsi),
    .legacy  (legacy)
  );

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_apic
    assign apic[n] = pirq_in[n] ||
                     (sci_in && (sci_gsi == GSI_IW'(NUM_LEGACY + n)));

    // R2: a raised line shows on its own APIC pin one clock later
    p_apic_follow_r2: assert property (@(posedge clk) disable iff (rst)
      pirq_in[n] |=> gsi_out[NUM_LEGACY + n]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gsi_out <= '0;
    end else begin
      gsi_out <= {apic, legacy};
    end
  end

  // R10: nothing asserted one clock after all sources are quiet
  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    ((pirq_in == '0) && !sci_in) |=> (gsi_out == '0));

  // R7: the SCI level lands on the pin selected when it was sampled
  p_sci_lands_r7: assert property (@(posedge clk) disable iff (rst)
    sci_in |=> gsi_out[$past(sci_gsi)]);

endmodule

// File: tb/sim_pirq_router.sv
module sim_pirq_router;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [7:0]  pirq_in;
  logic        sci_in;
  logic [23:0] gsi_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] rb [8];
  int         tgt;

  always #5 clk = ~clk;

  pirq_router u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pirq_in(pirq_in), .sci_in(sci_in), .gsi_out(gsi_out)
  );

  function automatic logic [23:0] model(input logic [7:0] p, input logic s);
    logic [23:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      if (p[i]) begin
        r[16 + i] = 1'b1;
        if (!rb[i][7] && (rb[i][6:0] < 7'd16)) r[rb[i][3:0]] = 1'b1;
      end
    end
    if (s) r[tgt] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_route(input int i, input logic [7:0] d);
    wr((i < 4) ? 8'(i) : 8'(8 + i - 4), d);
    rb[i] = d;
  endtask

  task automatic set_sci(input logic [2:0] c);
    wr(8'h10, {5'b0, c});
    case (c)
      3'd0: tgt = 9;
      3'd1: tgt = 10;
      3'd2: tgt = 11;
      3'd4: tgt = 20;
      3'd5: tgt = 21;
      default: ;
    endcase
  endtask

  task automatic drive(input logic [7:0] p, input logic s);
    @(negedge clk);
    pirq_in = p; sci_in = s;
    settle();
  endtask

  task automatic t_reset();
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    pirq_in = 8'hFF; sci_in = 1'b1;
    for (int i = 0; i < 8; i++) rb[i] = 8'h80;
    tgt = 9;
    repeat (3) @(negedge clk);
    chk("R1 outputs zero in reset", gsi_out, 24'h0);
    rst = 1'b0;
    drive(8'hFF, 1'b0);
    chk("R1 default steering apic only", gsi_out, 24'hFF0000);
    drive(8'h00, 1'b1);
    chk("R1 default sci on gsi9", gsi_out, 24'h000200);
    drive(8'h00, 1'b0);
  endtask

  task automatic t_apic();
    drive(8'hA5, 1'b0);
    chk("R2 apic pattern a5", gsi_out, model(8'hA5, 1'b0));
    drive(8'h5A, 1'b0);
    chk("R2 apic pattern 5a", gsi_out, model(8'h5A, 1'b0));
  endtask

  task automatic t_latency();
    drive(8'h00, 1'b0);
    @(negedge clk);
    pirq_in = 8'h08;
    #1;
    chk("R10 no change before edge", gsi_out, 24'h0);
    @(negedge clk);
    chk("R10 change after one edge", gsi_out, 24'h080000);
    pirq_in = 8'h00;
    settle();
  endtask

  task automatic t_legacy();
    set_route(0, 8'h05);
    drive(8'h01, 1'b0);
    chk("R3 line A to gsi5", gsi_out, 24'h010020);
    set_route(7, 8'h0F);
    drive(8'h80, 1'b0);
    chk("R3 line H to gsi15", gsi_out, 24'h808000);
    drive(8'h00, 1'b0);
  endtask

  task automatic t_share();
    set_route(1, 8'h05);
    set_route(2, 8'h05);
    drive(8'h02, 1'b0);
    chk("R4 shared B alone", gsi_out, model(8'h02, 1'b0));
    drive(8'h04, 1'b0);
    chk("R4 shared C alone", gsi_out, model(8'h04, 1'b0));
    drive(8'h06, 1'b0);
    chk("R4 shared B and C", gsi_out, model(8'h06, 1'b0));
    set_route(1, 8'h85);
    drive(8'h02, 1'b0);
    chk("R5 flag set keeps B off legacy", gsi_out, 24'h020000);
    drive(8'h04, 1'b0);
    chk("R5 C still on gsi5", gsi_out, 24'h040020);
    drive(8'h00, 1'b0);
  endtask

  task automatic t_range();
    set_route(5, 8'h10);
    drive(8'h20, 1'b0);
    chk("R6 irq 16 no legacy no wrap", gsi_out, 24'h200000);
    set_route(3, 8'h7F);
    drive(8'h08, 1'b0);
    chk("R6 irq 127 no legacy", gsi_out, 24'h080000);
    drive(8'h00, 1'b0);
  endtask

  task automatic t_sci();
    for (int c = 0; c < 6; c++) begin
      if (c != 3) begin
        set_sci(3'(c));
        drive(8'h00, 1'b1);
        chk($sformatf("R7 sci code %0d", c), gsi_out, model(8'h00, 1'b1));
        drive(8'h00, 1'b0);
      end
    end
  endtask

  task automatic t_reserved();
    set_sci(3'd1);
    set_sci(3'd3);
    drive(8'h00, 1'b1);
    chk("R8 code 3 keeps gsi10", gsi_out, 24'h000400);
    set_sci(3'd6);
    set_sci(3'd7);
    settle();
    chk("R8 codes 6 7 keep gsi10", gsi_out, 24'h000400);
    drive(8'h00, 1'b0);
  endtask

  task automatic t_move();
    set_sci(3'd2);
    drive(8'h00, 1'b1);
    chk("R9 sci held on gsi11", gsi_out, 24'h000800);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h10; wr_data = 8'h04;
    @(negedge clk);
    wr_en = 1'b0;
    tgt = 20;
    chk("R9 before move edge", gsi_out, 24'h000800);
    @(negedge clk);
    chk("R9 moved in one edge", gsi_out, 24'h100000);
    drive(8'h00, 1'b0);
  endtask

  task automatic t_addr();
    wr(8'h04, 8'h03);
    wr(8'h07, 8'h03);
    wr(8'h0C, 8'h03);
    wr(8'hFF, 8'h03);
    drive(8'hFF, 1'b0);
    chk("R11 gap writes ignored", gsi_out, model(8'hFF, 1'b0));
    set_route(4, 8'h03);
    drive(8'h10, 1'b0);
    chk("R11 line E at 0x08", gsi_out, 24'h100008);
    drive(8'h00, 1'b0);
  endtask

  initial begin
    t_reset();
    t_apic();
    t_latency();
    t_legacy();
    t_share();
    t_range();
    t_sci();
    t_reserved();
    t_move();
    t_addr();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule